// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits beside a two-port shared memory and watches the select and address of each port. When both ports are selected and point at the same word, it grants that word to one port and sends the other port an active-low busy flag. The same flag is turned into a write inhibit for the losing port, so that the two ports cannot corrupt the shared word. Arrival order is judged once per clock. A port counts as established if it was already selected at the same address in the previous cycle. If both ports arrive in the same cycle, the left port wins.

A mode input chooses between generating busy and accepting it. In master mode the arbiter drives the busy flags, and each port's write inhibit follows its own generated flag. In slave mode the busy flags are held inactive, and each port's write inhibit follows an external active-low busy input. This lets a wider memory built from several of these blocks take its busy decision from a single master.

Top module: `addr_match_arbiter`

## Requirements
- R1: In master mode, when either select input is high (deselected) or the two addresses differ, both busy flags are high and both write inhibits are low.
- R2: On a match, a port that was selected at the same address in the previous cycle wins over a port that was not. The loser's busy flag goes low in the first cycle of the match.
- R3: When neither port, or both ports, count as established on the first cycle of a match, the left port wins: right busy low, left busy high.
- R4: The two busy flags are never low in the same cycle.
- R5: The winner is kept for as long as the match lasts, even when both addresses move together to a new equal value.
- R6: Busy is released in the same cycle that the addresses stop matching or a select goes high.
- R7: In master mode, a port's write inhibit is high exactly when its own busy flag is low, and the external busy inputs have no effect.
- R8: In slave mode (mode input low), both busy flags stay high, and each port's write inhibit is high exactly when that port's external busy input is low.
- R9: While reset is high, both busy flags are high and both inhibits are low in master mode. After reset, the history is cleared, so a match already present counts as simultaneous (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = generate busy, 0 = take busy from inputs |
| left_cs_n | input | 1 | Left port select, active low |
| left_addr | input | 14 | Left port word address |
| left_busy_in_n | input | 1 | External busy for left port (slave mode), active low |
| right_cs_n | input | 1 | Right port select, active low |
| right_addr | input | 14 | Right port word address |
| right_busy_in_n | input | 1 | External busy for right port (slave mode), active low |
| left_busy_n | output | 1 | Left busy flag, active low |
| right_busy_n | output | 1 | Right busy flag, active low |
| left_wr_block | output | 1 | Inhibit left writes, active high |
| right_wr_block | output | 1 | Inhibit right writes, active high |

## Verification
The arbiter keeps two kinds of internal state: the previous-cycle history of each port and the held owner of an ongoing match. A stale history entry shows up in the first cycle of a new match, as busy on the wrong side. A lost or corrupted owner shows up one cycle into a match, when the busy flag flips sides while the addresses still agree. The stimulus therefore pairs each fresh-match cycle with at least one continuing-match cycle. This includes a cycle where both addresses jump together, which separates holding the owner from re-arbitrating.

// File: rtl/addr_arb_pkg.sv
package addr_arb_pkg;

    parameter int unsigned ARB_ADDR_W = 14;
    parameter int unsigned ARB_PORTS  = 2;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_t;

    typedef struct packed {
        logic                  sel;
        logic [ARB_ADDR_W-1:0] addr;
    } port_req_t;

    function automatic logic same_word(input port_req_t a, input port_req_t b);
        return a.sel && b.sel && (a.addr == b.addr);
    endfunction

endpackage

// File: rtl/port_tracker.sv
module port_tracker
    import addr_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req_i,
    output logic      est_o
);
    port_req_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= req_i;
        end
    end

    // established: selected now and last cycle, same address both times
    assign est_o = req_i.sel && prev_q.sel && (prev_q.addr == req_i.addr);
endmodule

// File: rtl/arb_core.sv
module arb_core
    import addr_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req_l,
    input  port_req_t req_r,
    input  logic      est_l,
    input  logic      est_r,
    output logic      hit_o,
    output logic      lose_l,
    output logic      lose_r
);
    owner_t owner, owner_q;
    logic   hit, hit_q;

    assign hit = same_word(req_l, req_r) && !rst;

    always_comb begin
        if (!hit) begin
            owner = OWN_NONE;
        end else if (hit_q) begin
            owner = owner_q;
        end else if (est_r && !est_l) begin
            owner = OWN_RIGHT;
        end else begin
            owner = OWN_LEFT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            hit_q   <= 1'b0;
        end else begin
            owner_q <= owner;
            hit_q   <= hit;
        end
    end

    assign hit_o  = hit;
    assign lose_l = (owner == OWN_RIGHT);
    assign lose_r = (owner == OWN_LEFT);

    // R5
    owner_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_q) |-> (owner_q != OWN_NONE));
endmodule

// File: rtl/busy_mux.sv
module busy_mux
    import addr_arb_pkg::*;
(
    input  logic                 master_sel,
    input  logic [ARB_PORTS-1:0] lose,
    input  logic [ARB_PORTS-1:0] ext_busy_n,
    output logic [ARB_PORTS-1:0] busy_n,
    output logic [ARB_PORTS-1:0] wr_block
);
    for (genvar p = 0; p < ARB_PORTS; p++) begin : g_side
        always_comb begin
            if (master_sel) begin
                busy_n[p]   = !lose[p];
                wr_block[p] = lose[p];
            end else begin
                busy_n[p]   = 1'b1;
                wr_block[p] = !ext_busy_n[p];
            end
        end
    end
endmodule

// File: rtl/addr_match_arbiter.sv
module addr_match_arbiter
    import addr_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  master_sel,
    input  logic                  left_cs_n,
    input  logic [ARB_ADDR_W-1:0] left_addr,
    input  logic                  left_busy_in_n,
    input  logic                  right_cs_n,
    input  logic [ARB_ADDR_W-1:0] right_addr,
    input  logic                  right_busy_in_n,
    output logic                  left_busy_n,
    output logic                  right_busy_n,
    output logic                  left_wr_block,
    output logic                  right_wr_block
);
    port_req_t            req [ARB_PORTS];
    logic [ARB_PORTS-1:0] est;
    logic [ARB_PORTS-1:0] lose;
    logic [ARB_PORTS-1:0] busy_n;
    logic [ARB_PORTS-1:0] wr_block;
    logic                 hit;

    assign req[0] = '{sel: !left_cs_n,  addr: left_addr};
    assign req[1] = '{sel: !right_cs_n, addr: right_addr};

    for (genvar p = 0; p < ARB_PORTS; p++) begin : g_trk
        port_tracker u_trk (
            .clk   (clk),
            .rst   (rst),
            .req_i (req[p]),
            .est_o (est[p])
        );
    end

    arb_core u_core (
        .clk    (clk),
        .rst    (rst),
        .req_l  (req[0]),
        .req_r  (req[1]),
        .est_l  (est[0]),
        .est_r  (est[1]),
        .hit_o  (hit),
        .lose_l (lose[0]),
        .lose_r (lose[1])
    );

    busy_mux u_mux (
        .master_sel (master_sel),
        .lose       (lose),
        .ext_busy_n ({right_busy_in_n, left_busy_in_n}),
        .busy_n     (busy_n),
        .wr_block   (wr_block)
    );

    assign left_busy_n    = busy_n[0];
    assign right_busy_n   = busy_n[1];
    assign left_wr_block  = wr_block[0];
    assign right_wr_block = wr_block[1];

    logic port_match;
    assign port_match = !left_cs_n && !right_cs_n && (left_addr == right_addr);

    // R4
    never_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(!left_busy_n && !right_busy_n));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !port_match |-> (left_busy_n && right_busy_n && !hit));

    // R5
    hold_right_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && !right_busy_n) |=> (!master_sel || !port_match || !right_busy_n));

    // R5
    hold_left_chk: assert property (@(posedge clk) disable iff (rst)
        (master_sel && !left_busy_n) |=> (!master_sel || !port_match || !left_busy_n));

    // R7
    master_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        master_sel |-> ((left_wr_block == !left_busy_n) && (right_wr_block == !right_busy_n)));

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_sel |-> (left_busy_n && right_busy_n));
endmodule

// File: tb/test_addr_match_arbiter.sv
`timescale 1ns/1ps
module test_addr_match_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms, lcs, rcs, lbi, rbi;
    logic [13:0] la, ra;
    logic lb, rb, lwb, rwb;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    addr_match_arbiter i_addr_match_arbiter (
        .clk(clk), .rst(rst), .master_sel(ms),
        .left_cs_n(lcs), .left_addr(la), .left_busy_in_n(lbi),
        .right_cs_n(rcs), .right_addr(ra), .right_busy_in_n(rbi),
        .left_busy_n(lb), .right_busy_n(rb),
        .left_wr_block(lwb), .right_wr_block(rwb)
    );

    typedef struct packed {
        logic        lcs;
        logic        rcs;
        logic [13:0] la;
        logic [13:0] ra;
        logic        ms;
        logic        lbi;
        logic        rbi;
        logic [3:0]  ex;   // {left_busy_n, right_busy_n, left_wr_block, right_wr_block}
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,14'd0,14'd0,1'b1,1'b1,1'b1,4'b1100,4'd1}, // R1 idle
        '{1'b0,1'b1,14'd5,14'd5,1'b1,1'b1,1'b1,4'b1100,4'd1}, // R1 one side only
        '{1'b0,1'b0,14'd5,14'd5,1'b1,1'b1,1'b1,4'b1001,4'd2}, // R2 left earlier
        '{1'b0,1'b0,14'd5,14'd5,1'b1,1'b1,1'b1,4'b1001,4'd5}, // R5 held
        '{1'b0,1'b0,14'd5,14'd6,1'b1,1'b1,1'b1,4'b1100,4'd6}, // R6 address split
        '{1'b0,1'b0,14'd5,14'd5,1'b1,1'b1,1'b1,4'b1001,4'd2}, // R2 right rejoins late
        '{1'b1,1'b0,14'd5,14'd5,1'b1,1'b1,1'b1,4'b1100,4'd6}, // R6 select drop
        '{1'b1,1'b1,14'd5,14'd5,1'b1,1'b1,1'b1,4'b1100,4'd1}, // R1
        '{1'b0,1'b0,14'd9,14'd9,1'b1,1'b1,1'b1,4'b1001,4'd3}, // R3 same-cycle tie
        '{1'b0,1'b0,14'd9,14'd9,1'b1,1'b1,1'b1,4'b1001,4'd5}, // R5
        '{1'b1,1'b1,14'd9,14'd9,1'b1,1'b1,1'b1,4'b1100,4'd1}, // R1
        '{1'b1,1'b0,14'd3,14'd3,1'b1,1'b1,1'b1,4'b1100,4'd1}, // R1
        '{1'b0,1'b0,14'd3,14'd3,1'b1,1'b1,1'b1,4'b0110,4'd2}, // R2 right earlier
        '{1'b0,1'b0,14'd3,14'd3,1'b1,1'b1,1'b1,4'b0110,4'd5}, // R5
        '{1'b0,1'b0,14'd7,14'd7,1'b1,1'b1,1'b1,4'b0110,4'd5}, // R5 both move together
        '{1'b1,1'b1,14'd7,14'd7,1'b1,1'b1,1'b1,4'b1100,4'd6}, // R6
        '{1'b0,1'b0,14'd2,14'd2,1'b0,1'b1,1'b0,4'b1101,4'd8}, // R8 slave, right ext
        '{1'b0,1'b0,14'd2,14'd2,1'b0,1'b0,1'b1,4'b1110,4'd8}, // R8 slave, left ext
        '{1'b0,1'b0,14'd2,14'd8,1'b1,1'b0,1'b0,4'b1100,4'd7}, // R7 ext ignored
        '{1'b0,1'b0,14'd2,14'd2,1'b1,1'b0,1'b0,4'b1001,4'd7}  // R7 own busy only
    };

    task automatic check(input logic [3:0] exp, input int rq, input string what);
        checks++;
        if ({lb, rb, lwb, rwb} !== exp) begin
            failures++;
            $display("FAIL R%0d %s: got %b expected %b", rq, what, {lb, rb, lwb, rwb}, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        ms = 1'b1; lbi = 1'b1; rbi = 1'b1;
        lcs = 1'b0; rcs = 1'b0; la = 14'd1; ra = 14'd1;
        // R9: matching inputs during reset give no busy
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            #1.5 check(4'b1100, 9, "busy during reset");
        end
        @(negedge clk);
        rst = 1'b0;
        // R9 then R3: history cleared, existing match is a tie
        #1.5 check(4'b1001, 9, "first match after reset");
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lcs = VEC[i].lcs; rcs = VEC[i].rcs;
            la  = VEC[i].la;  ra  = VEC[i].ra;
            ms  = VEC[i].ms;  lbi = VEC[i].lbi; rbi = VEC[i].rbi;
            #1.5 check(VEC[i].ex, int'(VEC[i].rq), $sformatf("vector %0d", i));
            // R4: never both busy
            checks++;
            if (!lb && !rb) begin
                failures++;
                $display("FAIL R4 vector %0d: got both low expected at most one", i);
            end
        end
        // R7 / R8 corner: slave with both external inputs low
        @(negedge clk);
        ms = 1'b0; lbi = 1'b0; rbi = 1'b0; lcs = 1'b1; rcs = 1'b1;
        #1.5 check(4'b1111, 8, "slave both external low");
        @(negedge clk);
        ms = 1'b1;
        #1.5 check(4'b1100, 7, "master ignores external low");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule